// File: doc/BRIEF.md
# Ring Tag Word Framer

This block moves 64-bit tags across a ring link that is 17 bits wide: sixteen data lines and one flag line. Each tag carries a 57-bit payload and a 7-bit single-error-correct, double-error-detect code. The transmit side sends the tag as four flagged 16-bit words, high word first, and then one unflagged idle word. The link is cut into fixed five-cycle slots. A slot with no pending tag carries four flagged all-zero words, so the flag line repeats 1111011110 for as long as the link is up. That repeating pattern is the heartbeat.

The receive side uses the flag line to find slot boundaries and rebuilds the 64-bit word. It checks the code and corrects any single flipped bit. It strobes the payload out together with a corrected flag and an uncorrectable flag. A flag run of the wrong length raises a one-cycle framing error and restarts word collection. A watchdog raises heartbeat-lost when no well-formed slot has completed for a set number of cycles. The line coding below the link and the meaning of the payload lie outside this block.

Top module: `ring_tag_framer`

## Requirements
- R1: Right after reset, the transmitter presents flag 0 and data 0 on `link_out` with `tx_ready` high. The receiver outputs `rx_valid`, `rx_frame_err` and `hb_lost` are all low.
- R2: A payload is accepted on the clock edge where `tx_valid` and `tx_ready` are both high. On the four cycles that follow, `link_out` carries flag 1 and codeword bits [63:48], [47:32], [31:16] and [15:0], in that order. On the fifth cycle it carries flag 0 and data 0.
- R3: The codeword layout depends on the Hamming positions 1 to 63.
  - Codeword bits [63:7] hold payload bits [56:0].
  - Payload bit k sits at the k-th position counted upward from 3 that is not a power of two.
  - Codeword bit 1+i is check i. It is the XOR of all positions whose index has bit i set.
  - Codeword bit 0 is set so that the whole 64-bit codeword has odd parity.
- R4: A slot with no accepted payload sends four flagged zero words and then the idle word. The flag line therefore always repeats 11110. `tx_ready` is high only during the idle cycle.
- R5: Four flagged words followed by an unflagged word form a nonzero codeword. On the edge that samples the unflagged word, `rx_valid` rises for exactly one cycle with the payload. If the codeword has no error, `rx_corrected` and `rx_uncorr` are both low.
- R6: A codeword with any one bit flipped, at any of the 64 positions, is delivered with the original payload and `rx_corrected` high.
- R7: A codeword with any two bits flipped is delivered with `rx_valid` and `rx_uncorr` high and `rx_corrected` low.
- R8: A slot whose four words are all zero is a heartbeat. It never raises `rx_valid`.
- R9: Either of two flag sequences raises `rx_frame_err` for one cycle, with no `rx_valid`:
  - a run of one to three flagged words followed by an unflagged word;
  - a fifth flagged word in a row.
  In the second case, the fifth word becomes word 0 of a new codeword.
- R10: `hb_lost` goes high once `LOST_CYCLES` consecutive clock edges have passed with no completed slot. It stays high until a slot completes and is low on the cycle after that slot completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | A payload is offered for sending |
| tx_payload | input | 57 | Payload to send |
| tx_ready | output | 1 | High during the idle cycle, when an offered payload is taken |
| link_out | output | 17 | Outgoing link word: bit 16 is the flag, bits 15:0 are data |
| link_in | input | 17 | Incoming link word: bit 16 is the flag, bits 15:0 are data |
| rx_valid | output | 1 | One-cycle strobe for a received payload |
| rx_payload | output | 57 | Received payload after correction |
| rx_corrected | output | 1 | A single-bit error was repaired (valid with rx_valid) |
| rx_uncorr | output | 1 | A double-bit error was detected (valid with rx_valid) |
| rx_frame_err | output | 1 | One-cycle strobe for a broken flag run |
| hb_lost | output | 1 | No completed slot for LOST_CYCLES edges |

## Verification
The assertions assume only that `link_in` moves by whole words, once per clock. They place no bound on flag runs, so they must hold under deliberate framing faults. The one case they leave open is an all-zero payload with its parity bit flipped: that word is indistinguishable from a heartbeat. The error sweeps therefore inject faults only into nonzero payloads. The stimulus changes `tx_valid` and `link_in` only on the falling edge. It also changes `tx_valid` only while `tx_ready` is high, so every accept falls on a known edge.

// File: rtl/rtf_pkg.sv
package rtf_pkg;
  localparam int WORD_W  = 16;
  localparam int WORDS   = 4;
  localparam int TAG_W   = WORD_W * WORDS;
  localparam int CHK_W   = 6;
  localparam int ECC_W   = CHK_W + 1;
  localparam int PAY_W   = TAG_W - ECC_W;
  localparam int LINK_W  = WORD_W + 1;
  localparam int POS_MAX = (1 << CHK_W) - 1;

  typedef logic [PAY_W-1:0] payload_t;
  typedef logic [TAG_W-1:0] tag_t;

  function automatic logic is_pow2(int pos);
    return (pos & (pos - 1)) == 0;
  endfunction

  // Check bits are the XOR of the Hamming positions that hold a one.
  function automatic logic [CHK_W-1:0] hm_checks(payload_t d);
    logic [CHK_W-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int pos = 1; pos <= POS_MAX; pos++) begin
      if (!is_pow2(pos)) begin
        if (k < PAY_W && d[k]) c = c ^ pos[CHK_W-1:0];
        k++;
      end
    end
    return c;
  endfunction

  function automatic tag_t tag_encode(payload_t d);
    logic [CHK_W-1:0] c;
    c = hm_checks(d);
    return {d, c, ~(^{d, c})};
  endfunction

  // Flip the payload bit at the given Hamming position, if it holds payload.
  function automatic payload_t fix_payload(payload_t d, logic [CHK_W-1:0] syn);
    payload_t r;
    int k;
    r = d;
    k = 0;
    for (int pos = 1; pos <= POS_MAX; pos++) begin
      if (!is_pow2(pos)) begin
        if (k < PAY_W && pos == int'(syn)) r[k] = ~r[k];
        k++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/rtf_tx.sv
module rtf_tx
  import rtf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  payload_t          tx_payload,
  output logic              tx_ready,
  output logic [LINK_W-1:0] link_out
);
  localparam logic [2:0] PH_IDLE = 3'(WORDS);

  logic [2:0] phase;
  tag_t       sh;
  tag_t       enc_now;

  assign enc_now  = tag_encode(tx_payload);
  assign tx_ready = (phase == PH_IDLE);
  assign link_out = tx_ready ? '0 : {1'b1, sh[TAG_W-1 -: WORD_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      sh    <= '0;
    end else if (phase == PH_IDLE) begin
      phase <= '0;
      sh    <= tx_valid ? enc_now : '0;
    end else begin
      phase <= phase + 3'd1;
      sh    <= sh << WORD_W;
    end
  end

  // R2: the first word on the link is the top of the encoded payload
  p_first_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (link_out == {1'b1, $past(enc_now[TAG_W-1 -: WORD_W])}));

  // R4: the idle word never repeats, so the flag pattern holds
  p_no_double_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !link_out[WORD_W] |=> link_out[WORD_W]);

  // R4: the accept window lasts a single cycle per slot
  p_ready_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);
endmodule

// File: rtl/rtf_rx.sv
module rtf_rx
  import rtf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINK_W-1:0] link_in,
  output logic              rx_valid,
  output payload_t          rx_payload,
  output logic              rx_corrected,
  output logic              rx_uncorr,
  output logic              rx_frame_err,
  output logic              slot_done
);
  localparam logic [2:0] FULL = 3'(WORDS);

  logic [2:0]        cnt;
  tag_t              sh;
  logic              flag;
  logic [WORD_W-1:0] word;
  logic              len_err;
  logic              tag_seen;
  payload_t          pay_raw;
  logic [CHK_W-1:0]  syn;
  logic              par_odd;
  logic              dbl_err;
  payload_t          pay_fixed;

  assign flag      = link_in[WORD_W];
  assign word      = link_in[WORD_W-1:0];
  assign slot_done = !flag && (cnt == FULL);
  assign len_err   = (flag && cnt == FULL) || (!flag && cnt != 3'd0 && cnt != FULL);
  assign tag_seen  = slot_done && (sh != '0);

  assign pay_raw   = sh[TAG_W-1:ECC_W];
  assign syn       = hm_checks(pay_raw) ^ sh[ECC_W-1:1];
  assign par_odd   = ^sh;
  assign dbl_err   = par_odd && (syn != '0);
  assign pay_fixed = par_odd ? pay_raw : fix_payload(pay_raw, syn);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt          <= '0;
      sh           <= '0;
      rx_valid     <= 1'b0;
      rx_payload   <= '0;
      rx_corrected <= 1'b0;
      rx_uncorr    <= 1'b0;
      rx_frame_err <= 1'b0;
    end else begin
      if (flag) begin
        sh  <= {sh[TAG_W-WORD_W-1:0], word};
        cnt <= (cnt == FULL) ? 3'd1 : cnt + 3'd1;
      end else begin
        cnt <= '0;
      end
      rx_valid     <= tag_seen;
      rx_corrected <= tag_seen && !par_odd;
      rx_uncorr    <= tag_seen && dbl_err;
      rx_frame_err <= len_err;
      if (tag_seen) rx_payload <= pay_fixed;
    end
  end

  // R5: the payload strobe lasts one cycle
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6: status flags only accompany a delivered payload
  p_status_with_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_corrected || rx_uncorr) |-> rx_valid);

  // R7: a payload is never both repaired and unrepairable
  p_status_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !(rx_corrected && rx_uncorr));

  // R9: a framing fault never coincides with a delivered payload
  p_err_without_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_err |-> !rx_valid);
endmodule

// File: rtl/rtf_hb_watch.sv
module rtf_hb_watch #(
  parameter int LOST_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_done,
  output logic hb_lost
);
  localparam int CW = $clog2(LOST_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOST_CYCLES);

  logic [CW-1:0] gap;

  assign hb_lost = (gap == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)         gap <= '0;
    else if (slot_done) gap <= '0;
    else if (!hb_lost)  gap <= gap + 1'b1;
  end

  // R10: a completed slot clears the alarm on the next cycle
  p_clear_on_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    slot_done |=> !hb_lost);

  // R10: the alarm holds until a slot completes
  p_alarm_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_lost && !slot_done) |=> hb_lost);
endmodule

// File: rtl/ring_tag_framer.sv
module ring_tag_framer
  import rtf_pkg::*;
#(
  parameter int LOST_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [PAY_W-1:0]  tx_payload,
  output logic              tx_ready,
  output logic [LINK_W-1:0] link_out,
  input  logic [LINK_W-1:0] link_in,
  output logic              rx_valid,
  output logic [PAY_W-1:0]  rx_payload,
  output logic              rx_corrected,
  output logic              rx_uncorr,
  output logic              rx_frame_err,
  output logic              hb_lost
);
  logic slot_done;

  rtf_tx tx_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid   (tx_valid),
    .tx_payload (tx_payload),
    .tx_ready   (tx_ready),
    .link_out   (link_out)
  );

  rtf_rx rx_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_in      (link_in),
    .rx_valid     (rx_valid),
    .rx_payload   (rx_payload),
    .rx_corrected (rx_corrected),
    .rx_uncorr    (rx_uncorr),
    .rx_frame_err (rx_frame_err),
    .slot_done    (slot_done)
  );

  rtf_hb_watch #(.LOST_CYCLES(LOST_CYCLES)) hb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_done (slot_done),
    .hb_lost   (hb_lost)
  );
endmodule

// File: tb/ring_tag_framer_tb_top.sv
`timescale 1ns/1ps
module ring_tag_framer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_valid = 1'b0;
  logic [56:0] tx_payload = '0;
  logic        tx_ready;
  logic [16:0] link_out;
  logic [16:0] link_in;
  logic [16:0] drv = '0;
  logic        loop = 1'b0;
  logic        rx_valid;
  logic [56:0] rx_payload;
  logic        rx_corrected;
  logic        rx_uncorr;
  logic        rx_frame_err;
  logic        hb_lost;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;
  assign link_in = loop ? link_out : drv;

  ring_tag_framer #(.LOST_CYCLES(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_payload(tx_payload),
    .tx_ready(tx_ready), .link_out(link_out), .link_in(link_in),
    .rx_valid(rx_valid), .rx_payload(rx_payload), .rx_corrected(rx_corrected),
    .rx_uncorr(rx_uncorr), .rx_frame_err(rx_frame_err), .hb_lost(hb_lost));

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Place bits at Hamming positions, then gather the parity of each mask.
  function automatic logic [63:0] b_enc(logic [56:0] d);
    logic [63:0] code;
    logic [5:0]  c;
    int k;
    code = '0;
    k = 0;
    for (int pos = 1; pos < 64; pos++)
      if ((pos & (pos - 1)) != 0) begin code[pos] = d[k]; k++; end
    for (int i = 0; i < 6; i++) begin
      c[i] = 1'b0;
      for (int pos = 1; pos < 64; pos++)
        if (((pos >> i) & 1) == 1) c[i] = c[i] ^ code[pos];
    end
    return {d, c, ~(^{d, c})};
  endfunction

  function automatic logic [56:0] pat(int n);
    logic [56:0] v;
    v = '0;
    for (int i = 0; i < 57; i++) v[i] = (((n * 37 + i * 11) ^ (i * n)) % 3) == 1;
    v[n % 57] = 1'b1;
    return v;
  endfunction

  // Drive n flagged words from t (high word first), optionally then the idle word.
  task automatic drive_words(logic [63:0] t, int n, bit idle);
    for (int w = 0; w < n; w++) begin
      @(negedge clk);
      drv = {1'b1, t[63 - 16 * w -: 16]};
    end
    if (idle) begin
      @(negedge clk);
      drv = '0;
    end
  endtask

  task automatic send_slot(logic [63:0] t);
    drive_words(t, 4, 1'b1);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] t;
    logic [56:0] p;
    logic [16:0] samp [20];
    int z;
    int waitc;
    bit got;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk(tx_ready == 1'b1 && link_out == '0, "R1 tx idle after reset", {tx_ready, link_out}, {1'b1, 17'd0});
    chk(!rx_valid && !rx_frame_err && !hb_lost, "R1 rx quiet after reset",
        {rx_valid, rx_frame_err, hb_lost}, 0);

    // R10: the link_in lines stay silent, so the alarm comes after 32 edges
    repeat (31) @(negedge clk);
    chk(hb_lost == 1'b0, "R10 no alarm after 31 edges", hb_lost, 0);
    @(negedge clk);
    chk(hb_lost == 1'b1, "R10 alarm after 32 edges", hb_lost, 1);
    drive_words(64'd0, 4, 1'b1);
    chk(hb_lost == 1'b1, "R10 alarm held mid-slot", hb_lost, 1);
    @(negedge clk);
    chk(hb_lost == 1'b0, "R10 alarm cleared by slot", hb_lost, 0);
    chk(rx_valid == 1'b0, "R8 heartbeat slot gives no payload", rx_valid, 0);

    // R4: heartbeat shape on the transmit side
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      samp[i] = link_out;
      chk(tx_ready == !link_out[16], "R4 ready only in idle cycle", tx_ready, !link_out[16]);
      chk(link_out[15:0] == 16'd0, "R4 heartbeat data zero", link_out[15:0], 0);
    end
    z = -1;
    for (int i = 0; i < 5; i++) if (z < 0 && !samp[i][16]) z = i;
    chk(z >= 0, "R4 idle word present", z, 0);
    for (int i = 0; i < 20; i++)
      if (z >= 0 && i >= z)
        chk(samp[i][16] == (((i - z) % 5) != 0), "R4 flag pattern 11110", samp[i][16], ((i - z) % 5) != 0);

    // R2 and R3: transmitted words
    for (int n = 0; n < 8; n++) begin
      p = (n == 0) ? '1 : (n == 1) ? 57'd1 : pat(n);
      t = b_enc(p);
      waitc = 0;
      @(negedge clk);
      while (!tx_ready && waitc < 10) begin @(negedge clk); waitc++; end
      tx_valid = 1'b1;
      tx_payload = p;
      @(negedge clk);
      tx_valid = 1'b0;
      for (int w = 0; w < 4; w++) begin
        if (w > 0) @(negedge clk);
        if (w == 3)
          chk(link_out == {1'b1, t[15:0]}, "R3 last word carries check code", link_out, {1'b1, t[15:0]});
        else
          chk(link_out == {1'b1, t[63 - 16 * w -: 16]}, "R2 tag word order", link_out, {1'b1, t[63 - 16 * w -: 16]});
      end
      @(negedge clk);
      chk(link_out == '0 && tx_ready, "R2 idle word after tag", link_out, 0);
    end

    // R5 and R8: loop the link back on itself
    loop = 1'b1;
    repeat (12) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!rx_valid && !rx_frame_err && !hb_lost, "R8 heartbeats silent on loopback",
          {rx_valid, rx_frame_err, hb_lost}, 0);
    end
    for (int n = 0; n < 6; n++) begin
      p = pat(n + 20);
      waitc = 0;
      while (!tx_ready && waitc < 10) begin @(negedge clk); waitc++; end
      tx_valid = 1'b1;
      tx_payload = p;
      @(negedge clk);
      tx_valid = 1'b0;
      got = 0;
      for (int c = 0; c < 10 && !got; c++) begin
        @(negedge clk);
        if (rx_valid) got = 1;
      end
      chk(got && rx_payload == p && !rx_corrected && !rx_uncorr, "R5 loopback payload",
          rx_payload, p);
    end
    loop = 1'b0;
    drv = '0;
    repeat (3) @(negedge clk);

    // R5: direct clean slot, strobe width
    p = pat(3);
    send_slot(b_enc(p));
    chk(rx_valid && rx_payload == p && !rx_corrected && !rx_uncorr, "R5 clean payload", rx_payload, p);
    @(negedge clk);
    chk(rx_valid == 1'b0, "R5 strobe one cycle", rx_valid, 0);

    // R6: every single-bit flip
    for (int b = 0; b < 64; b++) begin
      p = pat(b + 40);
      send_slot(b_enc(p) ^ (64'd1 << b));
      chk(rx_valid && rx_corrected && !rx_uncorr && rx_payload == p, "R6 single flip repaired",
          {rx_valid, rx_corrected, rx_uncorr, rx_payload[56:0]}, {3'b110, p});
    end

    // R7: two flips
    for (int b = 0; b < 64; b++) begin
      p = pat(b + 7);
      send_slot(b_enc(p) ^ (64'd1 << b) ^ (64'd1 << ((b + 1 + (b % 13)) % 64)));
      chk(rx_valid && rx_uncorr && !rx_corrected, "R7 double flip detected",
          {rx_valid, rx_corrected, rx_uncorr}, 3'b101);
    end

    // R9: short flag run
    drive_words(64'hABCD_1234_0000_0000, 2, 1'b1);
    @(negedge clk);
    chk(rx_frame_err && !rx_valid, "R9 short run flagged", {rx_frame_err, rx_valid}, 2'b10);
    @(negedge clk);
    chk(!rx_frame_err, "R9 error strobe one cycle", rx_frame_err, 0);

    // R9: five flags in a row, the fifth restarts a new tag
    p = pat(99);
    t = b_enc(p);
    drive_words(64'hAAAA_5555_F0F0_0F0F, 4, 1'b0);
    @(negedge clk);
    drv = {1'b1, t[63:48]};
    @(negedge clk);
    chk(rx_frame_err && !rx_valid, "R9 overlong run flagged", {rx_frame_err, rx_valid}, 2'b10);
    drv = {1'b1, t[47:32]};
    @(negedge clk);
    drv = {1'b1, t[31:16]};
    @(negedge clk);
    drv = {1'b1, t[15:0]};
    @(negedge clk);
    drv = '0;
    @(negedge clk);
    chk(rx_valid && rx_payload == p && !rx_frame_err, "R9 resync yields next tag", rx_payload, p);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule